// File: doc/BRIEF.md
# Cascadable Segment Row Capture

This block is the logic core of a 160-column segment driver that is chained with others of its kind to span one display row. Display data arrives on a parallel bus, one transfer per clock. A mode input selects the bus width: a full byte per clock, or a nibble per clock with two nibbles paired into one byte. Each assembled byte is written into a row buffer at a slot chosen by a byte pointer. A direction input sets the fill order. It also decides which of the two chain pins acts as the enable input and which acts as the enable output.

A falling latch pulse arms the chip. The chip selects itself on the first clock on which its chain input is low, and it captures the data present on that same clock. Once the last byte of the row is taken, the chip deselects and ignores further clocks. It then pulls its chain output low for exactly one clock so that the next chip continues without a gap. On every falling latch pulse, the row buffer is copied into a line latch.

Each column's 2-bit level code is formed from its line bit and a frame inversion input. A display-off input forces every code to ground and clears the line latch, while data capture goes on.

Top module: `seg_row_capture`

## Requirements
- R1: After reset, both chain outputs are high, the line latch is all zero, and every column shows the bit-0 level code.
- R2: With `wide_i` high, each selected clock writes one byte of `data_i`, and a full row takes COLS/8 clocks (20 at the default).
- R3: With `wide_i` low, the nibble on `data_i[3:0]` is taken on each selected clock. The first nibble of a pair forms byte bits 3:0 and the second forms bits 7:4. `data_i[7:4]` is ignored, and a full row takes COLS/4 clocks (40 at the default).
- R4: The chain output idles high. It is low for exactly the one clock period after the clock that took the last byte, and then returns high. After that byte the chip is deselected and takes no further data until it is re-armed.
- R5: A clock is taken only when the chip is already selected, or when it is armed by a falling latch pulse and its chain input is low in that clock. Without arming, a low chain input has no effect.
- R6: With `dir_i` low, `chain_b_i` is the enable input and `chain_a_o` is the enable output, and `chain_b_o` stays high. Fill position p (bit j of byte s, p = 8s + j) lands in column COLS-1-p. With `dir_i` high, the roles of the two pins swap and position p lands in column p.
- R7: On the clock that sees `lp_i` go from high to low, while `dispoff_ni` is high, the whole row buffer is copied into `line_o` at once. The new value is visible after that clock.
- R8: While `dispoff_ni` is low, every level code is 00 at once, the line latch is cleared on each clock and not loaded, and data capture into the row buffer continues.
- R9: Level code per column, from the line bit b and `fr_i`: b=1 with fr=1 gives 01, b=1 with fr=0 gives 00, b=0 with fr=1 gives 11, and b=0 with fr=0 gives 10.
- R10: After `dispoff_ni` returns high, every column shows the deselect code (11 when `fr_i` is high, 10 when it is low) until the next falling latch pulse loads the line latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data shift clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1 = byte per clock, 0 = nibble per clock |
| dir_i | input | 1 | Fill order and chain pin roles |
| data_i | input | 8 | Display data bus |
| lp_i | input | 1 | Latch pulse; its falling edge arms the chip and loads the line latch |
| fr_i | input | 1 | Frame inversion |
| dispoff_ni | input | 1 | Display off, active low |
| chain_a_i | input | 1 | Enable input when dir_i is high |
| chain_b_i | input | 1 | Enable input when dir_i is low |
| chain_a_o | output | 1 | Enable output when dir_i is low, else held high |
| chain_b_o | output | 1 | Enable output when dir_i is high, else held high |
| line_o | output | 160 | Line latch contents, one bit per column |
| level_o | output | 320 | Two-bit level code per column, column c at bits 2c+1:2c |

## Verification
Inputs change on the falling clock edge, and outputs are read at a falling edge. The chain output falls one clock after the clock that took the last byte and recovers one clock later. The bench therefore checks it at the falling edge directly after that clock, and again one edge later. A line latch load is due after the clock that sees the latch input low following a high, so the bench checks `line_o` at the falling edge after that clock. The effect of display-off on the level codes is combinational and is read 1 ns after the input changes. Its effect on the line latch is read after the following clock.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    LVL_GND = 2'b00,
    LVL_V0  = 2'b01,
    LVL_V12 = 2'b10,
    LVL_V43 = 2'b11
  } lvl_e;

  function automatic lvl_e lvl_of(input logic b, input logic fr);
    if (b) return fr ? LVL_V0 : LVL_GND;
    else   return fr ? LVL_V43 : LVL_V12;
  endfunction
endpackage

// File: rtl/seg_bus_packer.sv
module seg_bus_packer #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic [BW-1:0] data_i,
  input  logic          take_i,
  input  logic          clear_i,
  output logic [BW-1:0] byte_o,
  output logic          vld_o
);
  localparam int HW = BW / 2;

  logic          phase_q;
  logic [HW-1:0] low_q;

  assign vld_o  = take_i & (wide_i | phase_q);
  assign byte_o = wide_i ? data_i : {data_i[HW-1:0], low_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      low_q   <= '0;
    end else if (clear_i) begin
      phase_q <= 1'b0;
    end else if (take_i && !wide_i) begin
      phase_q <= ~phase_q;
      if (!phase_q) low_q <= data_i[HW-1:0];
    end
  end
endmodule

// File: rtl/seg_chain_ctrl.sv
module seg_chain_ctrl #(
  parameter int BYTES = 20,
  parameter int PTR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lp_i,
  input  logic             en_in_i,
  input  logic             vld_i,
  output logic             take_o,
  output logic             lp_fall_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             last_o,
  output logic             en_out_o
);
  logic             lp_q, armed_q, sel_q, pulse_q;
  logic [PTR_W-1:0] ptr_q;

  assign lp_fall_o = lp_q & ~lp_i;
  assign take_o    = sel_q | (armed_q & ~en_in_i);
  assign last_o    = vld_i & (ptr_q == PTR_W'(BYTES - 1));
  assign ptr_o     = ptr_q;
  assign en_out_o  = ~pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q    <= 1'b0;
      armed_q <= 1'b0;
      sel_q   <= 1'b0;
      pulse_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      lp_q    <= lp_i;
      pulse_q <= last_o & ~lp_fall_o;
      if (lp_fall_o) begin
        armed_q <= 1'b1;
        sel_q   <= 1'b0;
        ptr_q   <= '0;
      end else if (last_o) begin
        armed_q <= 1'b0;
        sel_q   <= 1'b0;
        ptr_q   <= '0;
      end else if (take_o) begin
        armed_q <= 1'b0;
        sel_q   <= 1'b1;
        if (vld_i) ptr_q <= ptr_q + PTR_W'(1);
      end
    end
  end
endmodule

// File: rtl/seg_row_latch.sv
module seg_row_latch #(
  parameter int COLS  = 160,
  parameter int BW    = 8,
  parameter int PTR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  input  logic             wr_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [BW-1:0]    byte_i,
  input  logic             lp_fall_i,
  input  logic             dispoff_ni,
  output logic [COLS-1:0]  row_o,
  output logic [COLS-1:0]  line_o,
  output logic             blank_o
);
  localparam int IDX_W = $clog2(COLS);

  logic [COLS-1:0] row_q, row_d, line_q;
  logic            blank_q;

  always_comb begin
    row_d = row_q;
    if (wr_i) begin
      for (int j = 0; j < BW; j++) begin
        if (dir_i) row_d[IDX_W'(int'(ptr_i) * BW + j)] = byte_i[j];
        else       row_d[IDX_W'(COLS - 1 - (int'(ptr_i) * BW + j))] = byte_i[j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      line_q  <= '0;
      blank_q <= 1'b0;
    end else begin
      row_q <= row_d;
      if (!dispoff_ni) begin
        line_q  <= '0;
        blank_q <= 1'b1;
      end else if (lp_fall_i) begin
        line_q  <= row_q;
        blank_q <= 1'b0;
      end
    end
  end

  assign row_o   = row_q;
  assign line_o  = line_q;
  assign blank_o = blank_q;
endmodule

// File: rtl/seg_level_map.sv
module seg_level_map
  import seg_pkg::*;
#(
  parameter int COLS = 160
) (
  input  logic [COLS-1:0]   line_i,
  input  logic              fr_i,
  input  logic              dispoff_ni,
  input  logic              blank_i,
  output logic [2*COLS-1:0] level_o
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    lvl_e code;
    always_comb begin
      if (!dispoff_ni)  code = LVL_GND;
      else if (blank_i) code = lvl_of(1'b0, fr_i);
      else              code = lvl_of(line_i[c], fr_i);
    end
    assign level_o[2*c +: 2] = code;
  end
endmodule

// File: rtl/seg_row_capture.sv
module seg_row_capture #(
  parameter int COLS = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              dir_i,
  input  logic [7:0]        data_i,
  input  logic              lp_i,
  input  logic              fr_i,
  input  logic              dispoff_ni,
  input  logic              chain_a_i,
  input  logic              chain_b_i,
  output logic              chain_a_o,
  output logic              chain_b_o,
  output logic [COLS-1:0]   line_o,
  output logic [2*COLS-1:0] level_o
);
  localparam int BW    = seg_pkg::BYTE_W;
  localparam int BYTES = COLS / BW;
  localparam int PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic             en_in, en_out, take, lp_fall, byte_vld, take_last, blank;
  logic [BW-1:0]    byte_w;
  logic [PTR_W-1:0] wr_ptr;
  logic [COLS-1:0]  row_q;

  assign en_in     = dir_i ? chain_a_i : chain_b_i;
  assign chain_a_o = dir_i ? 1'b1 : en_out;
  assign chain_b_o = dir_i ? en_out : 1'b1;

  seg_bus_packer #(.BW(BW)) u_pack (
    .clk_i, .rst_ni, .wide_i, .data_i,
    .take_i(take), .clear_i(lp_fall),
    .byte_o(byte_w), .vld_o(byte_vld)
  );

  seg_chain_ctrl #(.BYTES(BYTES), .PTR_W(PTR_W)) u_ctrl (
    .clk_i, .rst_ni, .lp_i,
    .en_in_i(en_in), .vld_i(byte_vld),
    .take_o(take), .lp_fall_o(lp_fall), .ptr_o(wr_ptr),
    .last_o(take_last), .en_out_o(en_out)
  );

  seg_row_latch #(.COLS(COLS), .BW(BW), .PTR_W(PTR_W)) u_latch (
    .clk_i, .rst_ni, .dir_i,
    .wr_i(byte_vld), .ptr_i(wr_ptr), .byte_i(byte_w),
    .lp_fall_i(lp_fall), .dispoff_ni,
    .row_o(row_q), .line_o, .blank_o(blank)
  );

  seg_level_map #(.COLS(COLS)) u_map (
    .line_i(line_o), .fr_i, .dispoff_ni, .blank_i(blank), .level_o
  );
endmodule

// File: rtl/seg_row_capture_chk.sv
module seg_row_capture_chk #(
  parameter int COLS  = 160,
  parameter int BYTES = 20,
  parameter int PTR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dir_i,
  input logic              dispoff_ni,
  input logic              chain_a_o,
  input logic              chain_b_o,
  input logic [COLS-1:0]   line_o,
  input logic [2*COLS-1:0] level_o,
  input logic              lp_fall,
  input logic              take_last,
  input logic              en_out,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic [COLS-1:0]   row_q
);
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ptr < PTR_W'(BYTES)); // R2

  AST_PULSE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_out |=> en_out); // R4

  AST_PULSE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_out |-> $past(take_last)); // R4

  AST_SPARE_PIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i ? chain_a_o : chain_b_o)); // R6

  AST_ROW_TO_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_fall && dispoff_ni) |=> line_o == $past(row_q)); // R7

  AST_DARK_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dispoff_ni |-> level_o == '0); // R8

  AST_DARK_LINE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dispoff_ni |=> line_o == '0); // R8
endmodule

bind seg_row_capture seg_row_capture_chk #(
  .COLS(COLS), .BYTES(BYTES), .PTR_W(PTR_W)
) u_chk (
  .clk_i, .rst_ni, .dir_i, .dispoff_ni, .chain_a_o, .chain_b_o,
  .line_o, .level_o, .lp_fall, .take_last, .en_out, .wr_ptr, .row_q
);

// File: tb/seg_row_capture_bench.sv
`timescale 1ns/1ps
module seg_row_capture_bench;
  localparam int COLS = 160;
  localparam int BW   = 8;
  localparam int NB   = COLS / BW;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wide_i = 1'b1, dir_i = 1'b0, lp_i = 1'b0, fr_i = 1'b0;
  logic              dispoff_ni = 1'b1, chain_a_i = 1'b1, chain_b_i = 1'b1;
  logic [7:0]        data_i = '0;
  logic              chain_a_o, chain_b_o;
  logic [COLS-1:0]   line_o;
  logic [2*COLS-1:0] level_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [BW-1:0]   bytes [NB];
  logic [COLS-1:0] exp_row;

  always #2.5 clk = ~clk;

  seg_row_capture #(.COLS(COLS)) u_seg_row_capture (
    .clk_i(clk), .rst_ni, .wide_i, .dir_i, .data_i, .lp_i, .fr_i, .dispoff_ni,
    .chain_a_i, .chain_b_i, .chain_a_o, .chain_b_o, .line_o, .level_o
  );

  task automatic chk(string req, logic [2*COLS-1:0] act, logic [2*COLS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*COLS-1:0] exp_level(logic [COLS-1:0] row, logic fr);
    logic [2*COLS-1:0] v;
    for (int c = 0; c < COLS; c++)
      v[2*c +: 2] = row[c] ? (fr ? 2'b01 : 2'b00) : (fr ? 2'b11 : 2'b10);
    return v;
  endfunction

  function automatic logic out_pin();
    return dir_i ? chain_b_o : chain_a_o;
  endfunction

  function automatic logic spare_pin();
    return dir_i ? chain_a_o : chain_b_o;
  endfunction

  task automatic set_en(logic v);
    chain_a_i = dir_i ? v : 1'b1;
    chain_b_i = dir_i ? 1'b1 : v;
  endtask

  task automatic gen_row(int seed);
    for (int s = 0; s < NB; s++) begin
      bytes[s] = BW'(seed * 53 + s * 29 + 7) ^ BW'(s << 3);
      for (int j = 0; j < BW; j++) begin
        int p = s * BW + j;
        exp_row[dir_i ? p : COLS - 1 - p] = bytes[s][j];
      end
    end
  endtask

  task automatic lp_pulse();
    @(negedge clk); lp_i = 1'b1; set_en(1'b1);
    @(negedge clk); lp_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_row(string req);
    int n = wide_i ? NB : 2 * NB;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == n - 1) chk({req, " R4 idle high before last"}, out_pin(), 1'b1);
      set_en(k == 0 ? 1'b0 : 1'b1);
      if (wide_i) data_i = bytes[k];
      else data_i = {4'(k * 3 + 9), (k % 2 == 1) ? bytes[k/2][7:4] : bytes[k/2][3:0]};
    end
    @(negedge clk);
    chk({req, " R4 chain out low"}, out_pin(), 1'b0);
    chk("R6 spare pin high", spare_pin(), 1'b1);
    data_i = 8'hFF;
    @(negedge clk);
    chk("R4 chain out back high", out_pin(), 1'b1);
    data_i = 8'h5A;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 line zero", line_o, '0);
    chk("R1 level", level_o, exp_level('0, 1'b0));
    chk("R1 chain outs", {chain_a_o, chain_b_o}, 2'b11);
  endtask

  task automatic t_unarmed();
    bit seen = 1'b0;
    dir_i = 1'b0; wide_i = 1'b1;
    for (int k = 0; k < NB + 5; k++) begin
      @(negedge clk);
      if (!out_pin()) seen = 1'b1;
      set_en(1'b0); data_i = 8'(k * 7 + 1);
    end
    @(negedge clk);
    if (!out_pin()) seen = 1'b1;
    chk("R5 no pulse without arming", seen, 1'b0);
    lp_pulse();
    for (int k = 0; k < NB + 5; k++) begin
      @(negedge clk);
      if (!out_pin()) seen = 1'b1;
      set_en(1'b1); data_i = 8'(k * 5 + 3);
    end
    chk("R5 no pulse with chain in high", seen, 1'b0);
    lp_pulse();
    chk("R5 nothing captured", line_o, '0);
  endtask

  task automatic t_row(logic wide, logic dir, int seed, string req);
    wide_i = wide; dir_i = dir; fr_i = 1'b0;
    lp_pulse();
    gen_row(seed);
    send_row(req);
    lp_pulse();
    chk({req, " R7 line load"}, line_o, exp_row);
    chk("R9 level fr=0", level_o, exp_level(exp_row, 1'b0));
    @(negedge clk); fr_i = 1'b1; #1;
    chk("R9 level fr=1", level_o, exp_level(exp_row, 1'b1));
    fr_i = 1'b0;
  endtask

  task automatic t_dispoff();
    logic [COLS-1:0] row_b;
    wide_i = 1'b1; dir_i = 1'b0; fr_i = 1'b1;
    @(negedge clk); dispoff_ni = 1'b0; #1;
    chk("R8 levels ground at once", level_o, '0);
    @(negedge clk);
    chk("R8 line cleared", line_o, '0);
    lp_pulse();
    chk("R8 no load while off", line_o, '0);
    gen_row(77);
    row_b = exp_row;
    send_row("R8 capture while off");
    @(negedge clk); dispoff_ni = 1'b1; #1;
    chk("R10 deselect code", level_o, exp_level('0, 1'b1));
    @(negedge clk);
    chk("R10 deselect held", level_o, exp_level('0, 1'b1));
    lp_pulse();
    chk("R8 row kept through off", line_o, row_b);
    chk("R10 line shown after load", level_o, exp_level(row_b, 1'b1));
  endtask

  initial begin
    t_reset();
    t_unarmed();
    t_row(1'b1, 1'b0, 3, "R2 byte mode");
    t_row(1'b0, 1'b0, 11, "R3 nibble mode");
    t_row(1'b1, 1'b1, 19, "R6 byte reversed");
    t_row(1'b0, 1'b1, 23, "R6 nibble reversed");
    t_dispoff();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule